// File: doc/BRIEF.md
# Tile Pitch Factor Decomposer

This unit takes a surface row pitch in bytes and derives the tile-grid parameters an address translator needs. Tiles are 256 bytes wide, so the unit first forms a tile count by discarding the eight low pitch bits. It then expresses that count as a small prime times a remaining factor. A pitch that is an exact power of two takes a shortcut and reports a prime of one. Any other pitch is tested against a short fixed list of odd primes, smallest first. The first prime that divides the count exactly wins.

Work begins with a one-cycle `start` while the unit is idle. Each divisibility test runs through a shared bit-serial divider, so the run time depends on how many primes are tried. `busy` covers the whole run. `done` pulses once when the result registers are loaded. The results then hold until the next `done`. A count that none of the primes divides raises `err`, and every result field reads zero.

Top module: `pitch_splitter`

## Requirements
- R1: The tile count is the pitch shifted right by eight; the eight low pitch bits never influence the tile count or the result fields.
- R2: When the full 32-bit pitch has at most one bit set, the result is prime 1, factor equal to the tile count, and `err` low.
- R3: Otherwise the divisors 3, 5, 7, 11, 13 are tried in that order. The first one leaving remainder zero is reported as prime, with the quotient as factor, even if a later divisor would also divide.
- R4: If no divisor in the list divides the tile count, `err` is high and prime, factor and tiles are all zero.
- R5: Whenever `done` is high with `err` low, tiles equals prime times factor.
- R6: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse. A `start` seen while `busy` is high has no effect on the run or its result.
- R7: prime, factor, tiles and `err` change only in a cycle where `done` is high, and hold otherwise.
- R8: A pitch of zero counts as a power of two: prime 1, factor 0, tiles 0, `err` low.
- R9: After reset, `busy`, `done`, `err`, prime, factor and tiles are all zero.
- R10: On the power-of-two path, `done` is high in the cycle right after the first rising edge following the edge that accepts `start`. Any run ends within 2 + 5*(tile-count width + 3) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a decomposition of `pitch` (honoured only when idle) |
| pitch | input | PITCH_W | Row pitch in bytes |
| busy | output | 1 | A decomposition is in progress |
| done | output | 1 | One-cycle pulse: result fields just loaded |
| err | output | 1 | Tile count has no divisor in the prime list |
| prime | output | PRIME_W | Selected prime (1 for power of two, 0 on error) |
| factor | output | PITCH_W-TILE_SHIFT | Tile count divided by prime |
| tiles | output | PITCH_W-TILE_SHIFT | Tiles per row, prime times factor |

## Verification
Two events can share a cycle: the completion pulse of one run and the `start` of the next. In that cycle the controller is already idle, so the new request must be taken. The bench drives `start` with a fresh pitch on the very cycle it observes `done`. It then checks that the old result was complete at that moment and that the next `done` carries the result for the new pitch. A second overlap is a `start` during a long trial-division run; it is judged by the first run's result arriving unchanged and by the absence of any extra `done` afterwards.

// File: rtl/pitch_split_pkg.sv
package pitch_split_pkg;

  localparam int NUM_PRIMES = 5;
  localparam int PRIME_W    = 4;
  localparam int IDX_W      = $clog2(NUM_PRIMES);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_DIV   = 2'd2
  } split_state_t;

  // Trial divisors, smallest first; the order decides which prime wins.
  function automatic logic [PRIME_W-1:0] prime_at(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    prime_at = 4'd3;
      3'd1:    prime_at = 4'd5;
      3'd2:    prime_at = 4'd7;
      3'd3:    prime_at = 4'd11;
      3'd4:    prime_at = 4'd13;
      default: prime_at = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/pow2_check.sv
module pow2_check #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  output logic         is_pow2
);

  logic [W-1:0] minus_one;

  assign minus_one = value - W'(1);
  assign is_pow2   = ((value & minus_one) == '0);

endmodule

// File: rtl/serial_divider.sv
module serial_divider #(
  parameter int DW = 24,
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic [VW:0]   remainder,
  output logic          ready
);

  localparam int CW = $clog2(DW + 1);

  logic [VW:0]   rem_q;
  logic [DW-1:0] quo_q;
  logic [VW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          rdy_q;

  logic [VW:0]   shifted;
  logic [VW:0]   diff;
  logic          fits;

  assign shifted = {rem_q[VW-1:0], quo_q[DW-1]};
  assign fits    = (shifted >= {1'b0, dvs_q});
  assign diff    = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= CW'(DW);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff : shifted;
        quo_q <= {quo_q[DW-2:0], fits};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          rdy_q <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign ready     = rdy_q;

endmodule

// File: rtl/pitch_splitter.sv
module pitch_splitter
  import pitch_split_pkg::*;
#(
  parameter int PITCH_W    = 32,
  parameter int TILE_SHIFT = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [PITCH_W-1:0]            pitch,
  output logic                          busy,
  output logic                          done,
  output logic                          err,
  output logic [PRIME_W-1:0]            prime,
  output logic [PITCH_W-TILE_SHIFT-1:0] factor,
  output logic [PITCH_W-TILE_SHIFT-1:0] tiles
);

  localparam int BW = PITCH_W - TILE_SHIFT;

  split_state_t       state_q;
  logic [PITCH_W-1:0] pitch_q;
  logic [IDX_W-1:0]   idx_q;
  logic               go_q;
  logic               done_q;
  logic               err_q;
  logic [PRIME_W-1:0] prime_q;
  logic [BW-1:0]      factor_q;
  logic [BW-1:0]      tiles_q;

  logic [BW-1:0]      base;
  logic               is_pow2;
  logic [PRIME_W-1:0] cur_prime;
  logic [BW-1:0]      quo;
  logic [PRIME_W:0]   rem;
  logic               div_ready;
  logic [BW-1:0]      prod;

  assign base      = pitch_q[PITCH_W-1:TILE_SHIFT];
  assign cur_prime = prime_at(idx_q);
  assign prod      = BW'(cur_prime) * quo;

  pow2_check #(.W(PITCH_W)) u_pow2 (
    .value   (pitch_q),
    .is_pow2 (is_pow2)
  );

  serial_divider #(.DW(BW), .VW(PRIME_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .go        (go_q),
    .dividend  (base),
    .divisor   (cur_prime),
    .quotient  (quo),
    .remainder (rem),
    .ready     (div_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pitch_q  <= '0;
      idx_q    <= '0;
      go_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      prime_q  <= '0;
      factor_q <= '0;
      tiles_q  <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            pitch_q <= pitch;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (is_pow2) begin
            prime_q  <= PRIME_W'(1);
            factor_q <= base;
            tiles_q  <= base;
            err_q    <= 1'b0;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            idx_q   <= '0;
            go_q    <= 1'b1;
            state_q <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_ready) begin
            if (rem == '0) begin
              prime_q  <= cur_prime;
              factor_q <= quo;
              tiles_q  <= prod;
              err_q    <= 1'b0;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (idx_q == IDX_W'(NUM_PRIMES - 1)) begin
              prime_q  <= '0;
              factor_q <= '0;
              tiles_q  <= '0;
              err_q    <= 1'b1;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              go_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign err    = err_q;
  assign prime  = prime_q;
  assign factor = factor_q;
  assign tiles  = tiles_q;

endmodule

// File: rtl/pitch_split_chk.sv
module pitch_split_chk
  import pitch_split_pkg::*;
#(
  parameter int PITCH_W    = 32,
  parameter int TILE_SHIFT = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          start,
  input logic                          busy,
  input logic                          done,
  input logic                          err,
  input logic [PRIME_W-1:0]            prime,
  input logic [PITCH_W-TILE_SHIFT-1:0] factor,
  input logic [PITCH_W-TILE_SHIFT-1:0] tiles
);

  localparam int BW      = PITCH_W - TILE_SHIFT;
  localparam int MAX_LAT = 2 + NUM_PRIMES * (BW + 3);
  localparam int LW      = $clog2(MAX_LAT + 2);

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else if (busy && lat_q != LW'(MAX_LAT + 1)) lat_q <= lat_q + LW'(1);
    else if (!busy) lat_q <= '0;
  end

  // R10: bounded run time
  always_ff @(posedge clk) begin
    if (!rst) begin
      a_r10_bounded_run: assert (lat_q <= LW'(MAX_LAT))
        else $error("run exceeded latency bound");
    end
  end

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_accept_goes_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r7_results_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(prime) && $stable(factor) && $stable(tiles) && $stable(err)));

  a_r4_error_zeroes: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (prime == '0 && factor == '0 && tiles == '0));

  a_r5_tiles_product: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (tiles == BW'(BW'(prime) * factor)));

endmodule

bind pitch_splitter pitch_split_chk #(.PITCH_W(PITCH_W), .TILE_SHIFT(TILE_SHIFT)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .err    (err),
  .prime  (prime),
  .factor (factor),
  .tiles  (tiles)
);

// File: tb/test_pitch_splitter.sv
module test_pitch_splitter;

  localparam int PW = 32;
  localparam int BW = 24;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [PW-1:0] pitch = '0;
  logic          busy, done, err;
  logic [3:0]    prime;
  logic [BW-1:0] factor, tiles;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pitch_splitter i_pitch_splitter (
    .clk(clk), .rst(rst), .start(start), .pitch(pitch),
    .busy(busy), .done(done), .err(err),
    .prime(prime), .factor(factor), .tiles(tiles)
  );

  // pitch, expected prime, expected factor, expected error
  localparam logic [31:0] V_PITCH [NV] = '{
    32'h0000_0100, 32'h0000_0000, 32'h0000_0080, 32'h8000_0000,
    32'h0000_0300, 32'h0000_0F00, 32'h0000_2300, 32'h0000_3100,
    32'h0000_7900, 32'h0000_A900, 32'h0000_C3FF, 32'h0000_1100,
    32'h0000_0180, 32'h0000_0003, 32'hFFFF_FF00, 32'h0000_4D00 };
  localparam logic [3:0] V_PRIME [NV] = '{
    4'd1, 4'd1, 4'd1, 4'd1, 4'd3, 4'd3, 4'd5, 4'd7,
    4'd11, 4'd13, 4'd3, 4'd0, 4'd0, 4'd3, 4'd3, 4'd7 };
  localparam logic [23:0] V_FACTOR [NV] = '{
    24'd1, 24'd0, 24'd0, 24'h80_0000, 24'd1, 24'd5, 24'd7, 24'd7,
    24'd11, 24'd13, 24'd65, 24'd0, 24'd0, 24'd0, 24'd5592405, 24'd11 };
  localparam logic V_ERR [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0 };

  task automatic check(input string req, input logic ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [PW-1:0] p);
    @(negedge clk);
    pitch = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input string req, input logic [3:0] ep,
                              input logic [BW-1:0] ef, input logic ee);
    logic [BW-1:0] et;
    et = BW'(BW'(ep) * ef);
    check(req, done == 1'b1, "done", done, 1);
    check(req, prime == ep, "prime", prime, ep);
    check(req, factor == ef, "factor", factor, ef);
    check(req, err == ee, "err", err, ee);
    check("R5", tiles == et, "tiles", tiles, et);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int lat;
    logic [3:0] hp;
    logic [BW-1:0] hf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9", busy == 1'b0, "busy", busy, 0);
    check("R9", done == 1'b0, "done", done, 0);
    check("R9", {err, prime, factor, tiles} == '0, "results", prime, 0);

    // Table walk: R1 R2 R3 R4 R8 R10
    for (int i = 0; i < NV; i++) begin
      pulse_start(V_PITCH[i]);
      check("R6", busy == 1'b1, "busy after start", busy, 1);
      wait_done(lat);
      check(V_ERR[i] ? "R4" : (V_PRIME[i] == 4'd1 ? "R2" : "R3"),
            1'b1, "vector", i, i);
      check_result(V_ERR[i] ? "R4" : (V_PRIME[i] == 4'd1 ? "R2" : "R3"),
                   V_PRIME[i], V_FACTOR[i], V_ERR[i]);
      if ((V_PITCH[i] & (V_PITCH[i] - 32'd1)) == 32'd0)
        check("R10", lat == 1, "pow2 latency", lat, 1);
      else
        check("R10", lat <= 2 + 5 * (BW + 3), "trial latency", lat, 2 + 5 * (BW + 3));
    end

    // R8: zero pitch with stale nonzero results beforehand
    pulse_start(32'h0000_0000);
    wait_done(lat);
    check_result("R8", 4'd1, 24'd0, 1'b0);

    // R1: low byte ignored (0x3FF vs 0x300 same result)
    pulse_start(32'h0000_03FF);
    wait_done(lat);
    check_result("R1", 4'd3, 24'd1, 1'b0);

    // R7: results hold after done while idle and with pitch wiggling
    hp = prime; hf = factor;
    @(negedge clk);
    pitch = 32'h0000_0F00;
    repeat (5) @(negedge clk);
    check("R7", prime == hp && factor == hf, "held prime", prime, hp);
    check("R6", done == 1'b0, "no spurious done", done, 0);

    // R6: start while busy is ignored
    pulse_start(32'h0000_1100);
    repeat (5) @(negedge clk);
    pitch = 32'h0000_0100;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7", prime == hp && factor == hf, "hold during run", prime, hp);
    wait_done(lat);
    check_result("R6", 4'd0, 24'd0, 1'b1);
    repeat (4) @(negedge clk);
    check("R6", busy == 1'b0 && done == 1'b0, "ignored start idle", busy, 0);

    // Start on the same cycle as done
    pulse_start(32'h0000_2300);
    wait_done(lat);
    check_result("R3", 4'd5, 24'd7, 1'b0);
    pitch = 32'h0000_0400;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6", busy == 1'b1 && done == 1'b0, "back-to-back accept", busy, 1);
    check("R7", prime == 4'd5, "old result kept", prime, 5);
    wait_done(lat);
    check_result("R2", 4'd1, 24'd4, 1'b0);
    check("R10", lat == 1, "back-to-back latency", lat, 1);

    // R9: reset mid-run
    pulse_start(32'h0000_1100);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", busy == 1'b0 && done == 1'b0, "reset idle", busy, 0);
    check("R9", {err, prime, factor, tiles} == '0, "reset results", prime, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule